// File: doc/BRIEF.md
# Handshaked Synchronous Bus Interface

This block pairs one bus master with a set of memory-mapped slaves on a shared synchronous bus. A local command port hands the master an address, a read/write flag and write data. The master drives the address, the command and, for writes, the data lines. It then waits a fixed skew delay before it raises master-ready, so that every line has settled before any slave samples it. Each slave compares the address with its own window, and only the slave that owns the address responds. That slave spends a fixed number of wait cycles on the fetch, puts read data on the data lines one cycle ahead of slave-ready, and holds it until the master lets go.

The exchange is four-phase. When the master sees slave-ready, it captures the data, pulses done and drops master-ready. The slave then drops slave-ready and releases the data lines. The master accepts no new command until slave-ready has fallen. If an address has no owner, the master gives up after a fixed timeout and reports an error. Data lines that nobody drives read as zero, because the lines are combined by OR and there is no tristate.

Top module: `hbus_system`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_done`, `rsp_err`, `bus_mrdy` and `bus_srdy` are all 0.
- R2: The address, command and write data are driven from the edge that accepts a command. `bus_mrdy` rises exactly SKEW cycles after that edge. The lines hold steady while `bus_mrdy` is high.
- R3: Slave i owns the addresses from i*DEPTH to i*DEPTH+DEPTH-1. Only the owning slave raises slave-ready, so at most one slave answers at a time.
- R4: The owning slave waits WAIT cycles, drives read data for one setup cycle, and then raises slave-ready. A mapped access therefore completes with `rsp_done` exactly SKEW+WAIT+3 cycles after the accepting edge.
- R5: `rsp_done` is a one-cycle pulse. It comes in the cycle the master captures data and drops `bus_mrdy`. `bus_srdy` falls one cycle after `bus_mrdy` falls.
- R6: A write stores `cmd_wdata` at the addressed word. A later read of that word returns it on `rsp_rdata` with `rsp_err` 0. A write returns `rsp_rdata` 0.
- R7: `cmd_ready` stays 0 while `bus_srdy` is 1, so no transfer starts before slave-ready has dropped.
- R8: An access with no owning slave ends with `rsp_done` and `rsp_err` both 1 and `rsp_rdata` 0. This happens SKEW+16 cycles after the accepting edge.
- R9: A write to an unmapped address changes no slave's contents, including the word whose low address bits it shares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; accepted on an edge where cmd_ready is 1 |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write data |
| cmd_ready | output | 1 | Master idle and able to accept a command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Valid with rsp_done; 1 when no slave answered |
| rsp_rdata | output | DW | Read data, valid with rsp_done |
| bus_mrdy | output | 1 | Master-ready line of the shared bus |
| bus_srdy | output | 1 | OR of all slave-ready lines |

## Verification
The bench measures the cycles from acceptance to the rise of master-ready and from acceptance to done. A master that skipped the skew wait, or a slave that dropped the setup cycle, shows up as an early completion. Accesses at the first and last word of each window catch a slave whose range compare is off by one: that slave would answer a neighbour's address or let two slaves answer at once. An unmapped write that aliases a mapped word in its low bits catches a decoder that ignores the upper address bits, because the later read returns the wrong value. At each done pulse the bench checks that slave-ready is still high and the command port is still closed. A master that skipped the release phase would reopen too early.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    M_IDLE, M_SKEW, M_WAIT, M_DROP
  } mst_state_t;

  typedef enum logic [1:0] {
    S_IDLE, S_FETCH, S_SETUP, S_ACK
  } slv_state_t;
endpackage

// File: rtl/hbus_master.sv
module hbus_master import hbus_pkg::*; #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int SKEW     = 2,
  parameter int TIMEOUT  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wr,
  output logic [DW-1:0] bus_mdata,
  output logic          bus_mrdy,
  input  logic          bus_srdy,
  input  logic [DW-1:0] bus_data
);
  localparam int CNT_MAX = (SKEW > TIMEOUT) ? SKEW : TIMEOUT;
  localparam int CW      = $clog2(CNT_MAX) + 1;

  mst_state_t    state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;

  assign cmd_ready = (state == M_IDLE);
  assign bus_addr  = addr_q;
  assign bus_wr    = wr_q;
  assign bus_mdata = (state != M_IDLE && wr_q) ? wdata_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= M_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      bus_mrdy  <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        M_IDLE: if (cmd_valid) begin
          addr_q  <= cmd_addr;
          wr_q    <= cmd_write;
          wdata_q <= cmd_wdata;
          cnt     <= '0;
          state   <= M_SKEW;
        end
        M_SKEW: if (cnt == CW'(SKEW - 1)) begin
          cnt      <= '0;
          bus_mrdy <= 1'b1;
          state    <= M_WAIT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        M_WAIT: if (bus_srdy) begin
          rsp_rdata <= wr_q ? '0 : bus_data;
          rsp_err   <= 1'b0;
          rsp_done  <= 1'b1;
          bus_mrdy  <= 1'b0;
          state     <= M_DROP;
        end else if (cnt == CW'(TIMEOUT - 1)) begin
          rsp_rdata <= '0;
          rsp_err   <= 1'b1;
          rsp_done  <= 1'b1;
          bus_mrdy  <= 1'b0;
          state     <= M_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        M_DROP: if (!bus_srdy) state <= M_IDLE;
        default: state <= M_IDLE;
      endcase
    end
  end

  AST_LINES_STEADY: assert property (@(posedge clk) disable iff (rst)
    (bus_mrdy && $past(bus_mrdy)) |-> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q))); // R2
  AST_NO_START_DURING_SRDY: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd_valid) |-> !bus_srdy); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R5
  AST_MRDY_LOW_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !bus_mrdy); // R5
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave import hbus_pkg::*; #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int BASE  = 0,
  parameter int WAIT  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_mrdy,
  input  logic [DW-1:0] bus_data,
  output logic          srdy,
  output logic [DW-1:0] sdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(WAIT) + 1;
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + DEPTH);

  slv_state_t    state;
  logic [CW-1:0] cnt;
  logic          sel;
  logic [AW-1:0] off;
  logic [IW-1:0] idx;
  logic          fetch_end;
  logic          drive_en;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] mem [DEPTH];

  assign sel       = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);
  assign off       = bus_addr - LO[AW-1:0];
  assign idx       = off[IW-1:0];
  assign fetch_end = (state == S_FETCH) && (cnt == CW'(WAIT - 1));
  assign sdata     = drive_en ? rd_q : '0;

  always_ff @(posedge clk) begin
    if (fetch_end) begin
      if (bus_wr) mem[idx] <= bus_data;
      rd_q <= mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      srdy     <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (bus_mrdy && sel) begin
          cnt   <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (fetch_end) begin
          drive_en <= !bus_wr;
          state    <= S_SETUP;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_SETUP: begin
          srdy  <= 1'b1;
          state <= S_ACK;
        end
        S_ACK: if (!bus_mrdy) begin
          srdy     <= 1'b0;
          drive_en <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SETUP_BEFORE_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(srdy) && !bus_wr) |-> $past(drive_en)); // R4
  AST_ACK_ONLY_WHEN_OWNED: assert property (@(posedge clk) disable iff (rst)
    $rose(srdy) |-> (sel && bus_mrdy)); // R3
  AST_RELEASE_AFTER_MRDY: assert property (@(posedge clk) disable iff (rst)
    (srdy && !bus_mrdy) |=> (!srdy && sdata == '0)); // R5
endmodule

// File: rtl/hbus_system.sv
module hbus_system import hbus_pkg::*; #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int NSLV    = 2,
  parameter int DEPTH   = 16,
  parameter int SKEW    = 2,
  parameter int WAIT    = 3,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_mrdy,
  output logic          bus_srdy
);
  logic [AW-1:0]   b_addr;
  logic            b_wr;
  logic [DW-1:0]   m_data;
  logic [DW-1:0]   b_data;
  logic [NSLV-1:0] srdy_vec;
  logic [DW-1:0]   s_data [NSLV];

  hbus_master #(.AW(AW), .DW(DW), .SKEW(SKEW), .TIMEOUT(TIMEOUT)) u_master (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(b_addr), .bus_wr(b_wr), .bus_mdata(m_data),
    .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy), .bus_data(b_data)
  );

  for (genvar i = 0; i < NSLV; i++) begin : g_slv
    hbus_slave #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BASE(i * DEPTH), .WAIT(WAIT)) u_slv (
      .clk(clk), .rst(rst),
      .bus_addr(b_addr), .bus_wr(b_wr), .bus_mrdy(bus_mrdy), .bus_data(b_data),
      .srdy(srdy_vec[i]), .sdata(s_data[i])
    );
  end

  always_comb begin
    b_data = m_data;
    for (int i = 0; i < NSLV; i++) b_data = b_data | s_data[i];
  end

  assign bus_srdy = |srdy_vec;

  AST_SINGLE_RESPONDER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(srdy_vec)); // R3
endmodule

// File: tb/hbus_system_tb.sv
module hbus_system_tb;
  localparam int AW = 8, DW = 16, NSLV = 2, DEPTH = 16, SKEW = 2, WAIT = 3, TMO = 16;
  localparam int LAT_OK  = SKEW + WAIT + 3;
  localparam int LAT_ERR = SKEW + TMO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_done, rsp_err, bus_mrdy, bus_srdy;
  logic [DW-1:0] rsp_rdata;

  always #4 clk = ~clk;

  hbus_system #(.AW(AW), .DW(DW), .NSLV(NSLV), .DEPTH(DEPTH), .SKEW(SKEW),
                .WAIT(WAIT), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy)
  );

  typedef struct {
    logic [DW-1:0] rdata;
    logic          err;
    int            lat;
    int            acc;
    string         req;
  } exp_t;

  exp_t expq[$];
  int checks = 0, fails = 0;
  int cyc = 0;
  int last_acc = 0;
  bit finished = 0;
  logic [DW-1:0] model [1 << AW];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [AW-1:0] a);
    return int'(a) < NSLV * DEPTH;
  endfunction

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string req);
    exp_t e;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    last_acc = cyc;
    e.acc = cyc;
    e.req = req;
    if (mapped(a)) begin
      e.err = 1'b0; e.lat = LAT_OK;
      if (wr) begin model[a] = d; e.rdata = '0; end
      else e.rdata = model[a];
    end else begin
      e.err = 1'b1; e.lat = LAT_ERR; e.rdata = '0;
    end
    expq.push_back(e);
  endtask

  // monitor / scoreboard
  initial begin
    logic prev_mrdy;
    prev_mrdy = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (bus_mrdy && !prev_mrdy)
          check(cyc - last_acc == SKEW, "R2", "mrdy rise delay", cyc - last_acc, SKEW);
        if (bus_srdy && cmd_ready)
          check(1'b0, "R7", "ready while srdy", 1, 0);
        prev_mrdy = bus_mrdy;
        if (rsp_done) begin
          exp_t e;
          if (expq.size() == 0) begin
            check(1'b0, "R5", "unexpected done", 1, 0);
          end else begin
            e = expq.pop_front();
            check(rsp_rdata == e.rdata, e.req, "rdata", rsp_rdata, e.rdata);
            check(rsp_err == e.err, e.req, "err", rsp_err, e.err);
            check(cyc - e.acc == e.lat, e.err ? "R8" : "R4", "latency", cyc - e.acc, e.lat);
            if (!e.err) begin
              check(bus_srdy && !cmd_ready && !bus_mrdy, "R7",
                    "srdy/ready/mrdy at done", {bus_srdy, cmd_ready, bus_mrdy}, 3'b100);
              @(negedge clk);
              prev_mrdy = bus_mrdy;
              check(!bus_srdy && !rsp_done && !bus_mrdy, "R5",
                    "release after done", {bus_srdy, rsp_done, bus_mrdy}, 3'b000);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready && !rsp_done && !rsp_err && !bus_mrdy && !bus_srdy, "R1", "reset outputs",
          {cmd_ready, rsp_done, rsp_err, bus_mrdy, bus_srdy}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready && !bus_mrdy && !bus_srdy, "R1", "after reset release",
          {cmd_ready, bus_mrdy, bus_srdy}, 3'b100);

    // R6 / R3: window edges of both slaves
    issue(1, 8'd0,  16'hA000, "R6");
    issue(1, 8'd15, 16'hA00F, "R3");
    issue(1, 8'd16, 16'hB010, "R3");
    issue(1, 8'd31, 16'hB01F, "R3");
    issue(1, 8'd3,  16'h1234, "R6");
    issue(0, 8'd15, '0, "R3");
    issue(0, 8'd16, '0, "R3");
    issue(0, 8'd0,  '0, "R6");
    issue(0, 8'd31, '0, "R6");
    issue(0, 8'd3,  '0, "R6");
    // overwrite and read back
    issue(1, 8'd3,  16'h5A5A, "R6");
    issue(0, 8'd3,  '0, "R6");
    // R8: unmapped read
    issue(0, 8'd40, '0, "R8");
    issue(0, 8'd255, '0, "R8");
    // R9: unmapped writes aliasing mapped words
    issue(1, 8'd35, 16'hDEAD, "R9");
    issue(1, 8'd48, 16'hBEEF, "R9");
    issue(0, 8'd3,  '0, "R9");
    issue(0, 8'd16, '0, "R9");
    issue(0, 8'd0,  '0, "R9");

    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule